// File: doc/BRIEF.md
# Chip-Select Pulse Clock Calibrator

This block produces a PWM tick from a fast system clock. The tick rate can be trimmed against a timing reference supplied by the host. The SPI decoder raises a one-cycle arm strobe when the calibration word is written. After that, the next low pulse on the raw chip-select line is timed in system-clock cycles. The measured width W stands for 128 tick periods, so the block then issues exactly 128 ticks in every W clock cycles. A fractional accumulator spreads the remainder of W/128 across the ticks, so the rate stays exact even when W is not a multiple of 128.

A pulse shorter than `MIN_CYC` or longer than `MAX_CYC` is thrown away. In that case the previous trim stays in force, or the default rate applies if no pulse has ever been accepted. Each arm allows one measurement, whether that pulse is accepted or rejected. A sticky flag shows that at least one calibration has been accepted since reset. Data shifted on the serial input while the pulse is being timed does not reach this block.

Top module: `cs_cal_top`

## Requirements
- R1: After reset, `calibrated` is 0 and the tick rate is the default: 128 ticks per `DEF_PERIOD` (1280) clock cycles, which is one tick every 10 cycles.
- R2: A chip-select low pulse that is not preceded by an arm strobe changes neither the tick rate nor `calibrated`.
- R3: The measured width is the number of clock cycles that `cs_n` stays low, from its falling edge to its next rising edge. If the arm strobe arrives while `cs_n` is already low, the block waits for the next falling edge.
- R4: After an accepted width W that is a multiple of 128, `tick` pulses for one cycle every W/128 cycles. `tick` is never high in two consecutive cycles.
- R5: After an accepted width W that is not a multiple of 128, any window of W consecutive cycles holds exactly 128 ticks.
- R6: A width below `MIN_CYC` (256) is rejected. A width of exactly `MIN_CYC` is accepted.
- R7: A width above `MAX_CYC` (4096) is rejected, because the width counter saturates at `MAX_CYC`. A width of exactly `MAX_CYC` is accepted.
- R8: A rejected pulse keeps the previously accepted rate, or keeps the default rate if no pulse has been accepted since reset.
- R9: One arm allows exactly one measurement. After that pulse, accepted or rejected, further pulses are ignored until the next arm.
- R10: `calibrated` goes to 1 on the first accepted pulse and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle strobe from the SPI decoder when the calibration word is written |
| cs_n | input | 1 | Raw, asynchronous chip-select line, active low |
| tick | output | 1 | One-cycle PWM tick |
| calibrated | output | 1 | Sticky flag: at least one pulse has been accepted |

## Verification
The hardest situation to reach from the ports is an arm strobe that arrives while chip-select is already low. The stimulus drops `cs_n`, arms partway through that low phase, and releases the line. It then sends a proper pulse and checks that the tick rate matches the second pulse only. The two limit widths also need care. The stimulus holds `cs_n` low for exactly `MIN_CYC`, exactly `MAX_CYC`, and one cycle beyond each limit, so that the saturation point of the counter is hit on the exact cycle. The trim is always read back by counting ticks over a window of W cycles.

// File: rtl/cs_cal_pkg.sv
package cs_cal_pkg;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARMED = 2'd1,
        MS_MEAS  = 2'd2
    } meter_st_t;

    typedef struct packed {
        logic done;
        logic accept;
    } meter_evt_t;

    localparam int TICKS_PER_REF = 128;

    function automatic logic width_ok(input logic saturated, input logic short_pulse);
        return !saturated && !short_pulse;
    endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], raw_n};
            prev  <= chain[STAGES-1];
        end
    end

    assign fall = prev && !chain[STAGES-1];
    assign rise = !prev && chain[STAGES-1];
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import cs_cal_pkg::*;
#(
    parameter int MIN_CYC = 256,
    parameter int MAX_CYC = 4096,
    parameter int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             fall,
    input  logic             rise,
    output meter_evt_t       evt,
    output logic [CNT_W-1:0] width,
    output meter_st_t        state
);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(MIN_CYC);

    meter_st_t        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             over_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= MS_IDLE;
            cnt_q  <= '0;
            over_q <= 1'b0;
        end else begin
            unique case (st_q)
                MS_IDLE: begin
                    if (arm) st_q <= MS_ARMED;
                end
                MS_ARMED: begin
                    if (fall) begin
                        st_q   <= MS_MEAS;
                        cnt_q  <= CNT_W'(1);
                        over_q <= 1'b0;
                    end
                end
                MS_MEAS: begin
                    if (rise) begin
                        st_q <= MS_IDLE;
                    end else if (cnt_q == LIM_HI) begin
                        over_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= MS_IDLE;
            endcase
        end
    end

    always_comb begin
        evt.done   = (st_q == MS_MEAS) && rise;
        evt.accept = evt.done && width_ok(over_q, cnt_q < LIM_LO);
    end

    assign width = cnt_q;
    assign state = st_q;
endmodule

// File: rtl/tick_gen.sv
module tick_gen
    import cs_cal_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    localparam int ACC_W = CNT_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(TICKS_PER_REF);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] per_ext;
    logic             wrap;

    assign per_ext = {1'b0, period};
    assign sum     = acc_q + STEP;
    assign wrap    = sum >= per_ext;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= wrap ? (sum - per_ext) : sum;
            tick  <= wrap;
        end
    end
endmodule

// File: rtl/cs_cal_top.sv
module cs_cal_top
    import cs_cal_pkg::*;
#(
    parameter int MIN_CYC    = 256,
    parameter int MAX_CYC    = 4096,
    parameter int DEF_PERIOD = 1280,
    parameter int SYNC_STG   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic cs_n,
    output logic tick,
    output logic calibrated
);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PER_RST = CNT_W'(DEF_PERIOD);

    logic             cs_fall;
    logic             cs_rise;
    meter_evt_t       evt;
    logic [CNT_W-1:0] meas_w;
    meter_st_t        meas_st;
    logic [CNT_W-1:0] period_q;
    logic             cal_load;

    cs_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw_n(cs_n),
        .fall (cs_fall),
        .rise (cs_rise)
    );

    pulse_meter #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_meter (
        .clk  (clk),
        .rst  (rst),
        .arm  (arm),
        .fall (cs_fall),
        .rise (cs_rise),
        .evt  (evt),
        .width(meas_w),
        .state(meas_st)
    );

    assign cal_load = evt.accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q   <= PER_RST;
            calibrated <= 1'b0;
        end else if (cal_load) begin
            period_q   <= meas_w;
            calibrated <= 1'b1;
        end
    end

    tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .restart(cal_load),
        .period (period_q),
        .tick   (tick)
    );
endmodule

// File: rtl/cs_cal_chk.sv
module cs_cal_chk
    import cs_cal_pkg::*;
#(
    parameter int MIN_CYC = 256,
    parameter int MAX_CYC = 4096,
    parameter int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             calibrated,
    input logic             load,
    input logic [CNT_W-1:0] period,
    input meter_st_t        meas_st
);
    // R10
    calib_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        calibrated |=> calibrated);

    // R10
    calib_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(calibrated) |-> $past(load));

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R6
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        (period >= CNT_W'(MIN_CYC)) && (period <= CNT_W'(MAX_CYC)));

    // R8
    period_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(period) |-> $past(load));

    // R3
    load_state_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (meas_st == MS_MEAS));
endmodule

bind cs_cal_top cs_cal_chk #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .calibrated(calibrated),
    .load      (cal_load),
    .period    (period_q),
    .meas_st   (meas_st)
);

// File: tb/tb_cs_cal_top.sv
module tb_cs_cal_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic cs_n = 1'b1;
    logic tick;
    logic calibrated;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cs_cal_top dut (
        .clk(clk), .rst(rst), .arm(arm), .cs_n(cs_n),
        .tick(tick), .calibrated(calibrated)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic pulse(input int len);
        @(negedge clk) cs_n = 1'b0;
        repeat (len) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic count_ticks(input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
    endtask

    task automatic rate_is(input string req, input int w);
        int n;
        count_ticks(w, n);
        check(req, n, 128);
    endtask

    task automatic t_reset();
        check("R1 calibrated", int'(calibrated), 0);
        rate_is("R1 default rate", 1280);
    endtask

    task automatic t_no_arm();
        pulse(1664);
        check("R2 calibrated", int'(calibrated), 0);
        rate_is("R2 rate", 1280);
    endtask

    task automatic t_reject_default();
        do_arm(); pulse(255);
        check("R6 short calibrated", int'(calibrated), 0);
        rate_is("R8 short keeps default", 1280);
        do_arm(); pulse(4097);
        check("R7 long calibrated", int'(calibrated), 0);
        rate_is("R8 long keeps default", 1280);
        pulse(1664);
        rate_is("R9 after reject", 1280);
    endtask

    task automatic t_accept_int();
        int n;
        do_arm(); pulse(1664);
        check("R10 calibrated set", int'(calibrated), 1);
        rate_is("R4 rate 1664", 1664);
        count_ticks(13, n);
        check("R4 one per 13", n, 1);
    endtask

    task automatic t_fraction();
        int n;
        do_arm(); pulse(1300);
        rate_is("R5 window 1300", 1300);
        count_ticks(2600, n);
        check("R5 window 2600", n, 256);
    endtask

    task automatic t_reject_keep();
        do_arm(); pulse(5000);
        rate_is("R8 keeps 1300", 1300);
        check("R10 still set", int'(calibrated), 1);
        pulse(2000);
        rate_is("R9 unarmed after", 1300);
    endtask

    task automatic t_limits();
        int n;
        do_arm(); pulse(256);
        count_ticks(256, n);
        check("R6 min accepted", n, 128);
        do_arm(); pulse(4096);
        count_ticks(4096, n);
        check("R7 max accepted", n, 128);
    endtask

    task automatic t_arm_while_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (200) @(negedge clk);
        do_arm();
        repeat (200) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        rate_is("R3 partial pulse not taken", 4096);
        pulse(1536);
        rate_is("R3 next pulse taken", 1536);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_arm();
        t_reject_default();
        t_accept_int();
        t_fraction();
        t_reject_keep();
        t_limits();
        t_arm_while_low();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule